// File: doc/BRIEF.md
# I2C Control-Register Sequencer

This block is the command and bus-state front end of an I2C serial port. A CPU writes one 8-bit control register through a simple write strobe and can read it back. Three of its bits act as commands. The enable bit switches the port on or off. The exit bit abandons the current transfer and parks the port in standby. The wait-release bit ends a clock-stretch wait.

A bus-condition detector reports start, stop, address-match, extension-code and ACK events. The shift and arbitration logic reports when the port becomes master or transmitter, and raises a one-cycle pulse at the ninth-clock wait. From these inputs the block keeps a status byte and drives two open-drain drive-low enables, one for SCL and one for SDA. It also decides when a standby session may resume.

Standby ends in one of two ways. A stop condition ends it and lets master operation begin again. An address match or extension code ends it, but only after a start condition has been seen while in standby.

Top module: `i2c_ctl_seq`

## Requirements
- R1: After reset the control register reads 0x00, the status byte is 0x00, both drive-low enables are 0 and standby is 0.
- R2: Control bits: bit 7 enable, bit 6 exit command, bit 5 wait-release command, bit 4 stop-interrupt enable, bit 3 wait-timing select, bit 2 ACK enable, bit 1 start trigger, bit 0 stop trigger. Written bits read back on the next cycle, but bits 6 and 5 always read 0.
- R3: While enable reads 0, a write changes only the enable bit, and no bus event or datapath report sets any status bit.
- R4: A write that clears enable clears the control register, the whole status byte (including bus-busy and start-detected), any pending wait and standby, all on the next clock edge.
- R5: Status bits: 7 master, 6 bus busy, 5 extension code, 4 address match, 3 transmit mode, 2 ACK detected, 1 start detected, 0 stop detected. An exit command clears bits 7, 5, 4, 3, 2 and 1 and the start and stop triggers, keeps bits 6 and 0, enters standby and releases both lines.
- R6: In standby, master, transmit, ACK and ninth-clock-wait reports are ignored.
- R7: A stop condition in standby ends standby, clears bus busy and every status bit but stop detected, and sets stop detected. A later master report is accepted again.
- R8: In standby, an address match or extension code ends standby and sets its flag only if a start condition has been seen since standby began. Otherwise it is ignored.
- R9: A ninth-clock-wait pulse while enabled and not in standby holds SCL low until a wait release. A wait release with no pending wait changes nothing.
- R10: A wait release during a wait in transmit mode releases SCL and SDA and clears transmit mode, on the next edge.
- R11: Turning enable on while SCL is high, SDA is low and the input filter is on sets start detected and bus busy at once. An exit command issued right after clears start detected.
- R12: When an exit command and status-setting events arrive in the same cycle, the exit clears win.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Control register write strobe |
| wrData | input | 8 | Control register write data |
| rdData | output | 8 | Control register read value |
| sclIn | input | 1 | Sampled SCL line level |
| sdaIn | input | 1 | Sampled SDA line level |
| filterOn | input | 1 | Input filter enabled |
| evStart | input | 1 | Start condition detected (pulse) |
| evStop | input | 1 | Stop condition detected (pulse) |
| evAddrMatch | input | 1 | Own address matched (pulse) |
| evExtCode | input | 1 | Extension code received (pulse) |
| evAckDet | input | 1 | ACK detected (pulse) |
| setMaster | input | 1 | Port became bus master (pulse) |
| setTx | input | 1 | Port entered transmit mode (pulse) |
| ninthWait | input | 1 | Ninth-clock wait begins (pulse) |
| txBitLow | input | 1 | Shift register wants SDA low |
| statusOut | output | 8 | Status byte |
| sclDrvLow | output | 1 | Open-drain SCL drive-low enable |
| sdaDrvLow | output | 1 | Open-drain SDA drive-low enable |
| standby | output | 1 | Port parked after an exit command |

## Verification
The hardest case to reach from the ports is the standby exit guarded by a start condition. An address match must be shown to have no effect before any start and to end standby after one. The stimulus therefore sends an exit command, then a bare address match, then a start condition, then a second address match, checking the state after each. Wait release in transmit mode needs a prior master report, a transmit report and a ninth-clock pulse, so the vector table builds that history row by row before the release write.

// File: rtl/i2c_ctl_pkg.sv
package i2c_ctl_pkg;
  localparam int CTRL_W = 8;
  localparam int STAT_W = 8;

  // control register bit positions
  localparam int B_EN   = 7;
  localparam int B_EXIT = 6;
  localparam int B_WREL = 5;
  localparam int B_STT  = 1;
  localparam int B_SPT  = 0;

  // status bit positions
  localparam int S_MST  = 7;
  localparam int S_BUSY = 6;
  localparam int S_EXT  = 5;
  localparam int S_ADDR = 4;
  localparam int S_TRC  = 3;
  localparam int S_ACK  = 2;
  localparam int S_STD  = 1;
  localparam int S_SPD  = 0;

  localparam logic [CTRL_W-1:0] CMD_MASK = CTRL_W'((1 << B_EXIT) | (1 << B_WREL));
  localparam logic [STAT_W-1:0] EXIT_CLR = STAT_W'((1 << S_MST) | (1 << S_EXT) |
    (1 << S_ADDR) | (1 << S_TRC) | (1 << S_ACK) | (1 << S_STD));

  typedef struct packed {
    logic en;
    logic exitCmd;
    logic waitRel;
    logic disableCmd;
    logic glitchStart;
  } ctlStrobe_t;
endpackage

// File: rtl/i2c_ctl_regs.sv
module i2c_ctl_regs
  import i2c_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [CTRL_W-1:0] wrData,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              filterOn,
  output logic [CTRL_W-1:0] rdData,
  output ctlStrobe_t        strobe
);
  logic [CTRL_W-1:0] ctrlQ;
  logic enQ;

  assign enQ = ctrlQ[B_EN];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ <= '0;
    end else if (wrEn) begin
      if (!enQ) begin
        // only the enable bit is live while disabled
        ctrlQ       <= '0;
        ctrlQ[B_EN] <= wrData[B_EN];
      end else if (!wrData[B_EN]) begin
        ctrlQ <= '0;
      end else begin
        ctrlQ <= wrData & ~CMD_MASK;
        if (wrData[B_EXIT]) begin
          ctrlQ[B_STT] <= 1'b0;
          ctrlQ[B_SPT] <= 1'b0;
        end
      end
    end
  end

  assign rdData = ctrlQ;

  always_comb begin
    strobe.en          = enQ;
    strobe.exitCmd     = wrEn && enQ && wrData[B_EN] && wrData[B_EXIT];
    strobe.waitRel     = wrEn && enQ && wrData[B_EN] && wrData[B_WREL];
    strobe.disableCmd  = wrEn && enQ && !wrData[B_EN];
    strobe.glitchStart = wrEn && !enQ && wrData[B_EN] && sclIn && !sdaIn && filterOn;
  end
endmodule

// File: rtl/i2c_ctl_flags.sv
module i2c_ctl_flags
  import i2c_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic              evStart,
  input  logic              evStop,
  input  logic              evAddrMatch,
  input  logic              evExtCode,
  input  logic              evAckDet,
  input  logic              setMaster,
  input  logic              setTx,
  input  logic              ninthWait,
  input  logic              txBitLow,
  output logic [STAT_W-1:0] statusOut,
  output logic              sclDrvLow,
  output logic              sdaDrvLow,
  output logic              standby
);
  logic [STAT_W-1:0] statQ;
  logic standbyQ, sawStartQ, waitHoldQ;
  logic setOk, wakeOk;

  assign setOk  = strobe.en && !standbyQ;
  assign wakeOk = strobe.en && standbyQ && sawStartQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      statQ     <= '0;
      standbyQ  <= 1'b0;
      sawStartQ <= 1'b0;
      waitHoldQ <= 1'b0;
    end else begin
      // bus conditions are tracked whenever enabled
      if (strobe.en && evStart) begin
        statQ[S_STD]  <= 1'b1;
        statQ[S_BUSY] <= 1'b1;
        statQ[S_SPD]  <= 1'b0;
        if (standbyQ) sawStartQ <= 1'b1;
      end
      if (strobe.en && evStop) begin
        statQ         <= '0;
        statQ[S_SPD]  <= 1'b1;
        standbyQ      <= 1'b0;
        sawStartQ     <= 1'b0;
        waitHoldQ     <= 1'b0;
      end
      if ((setOk || wakeOk) && evAddrMatch) statQ[S_ADDR] <= 1'b1;
      if ((setOk || wakeOk) && evExtCode)   statQ[S_EXT]  <= 1'b1;
      if (wakeOk && (evAddrMatch || evExtCode)) begin
        standbyQ  <= 1'b0;
        sawStartQ <= 1'b0;
      end
      if (setOk && setMaster) statQ[S_MST] <= 1'b1;
      if (setOk && setTx)     statQ[S_TRC] <= 1'b1;
      if (setOk && evAckDet)  statQ[S_ACK] <= 1'b1;
      if (setOk && ninthWait) waitHoldQ    <= 1'b1;
      if (strobe.waitRel && waitHoldQ) begin
        waitHoldQ    <= 1'b0;
        statQ[S_TRC] <= 1'b0;
      end
      if (strobe.glitchStart) begin
        statQ[S_STD]  <= 1'b1;
        statQ[S_BUSY] <= 1'b1;
      end
      // exit and disable override every set above
      if (strobe.exitCmd) begin
        statQ     <= statQ & ~EXIT_CLR;
        standbyQ  <= 1'b1;
        sawStartQ <= 1'b0;
        waitHoldQ <= 1'b0;
      end
      if (strobe.disableCmd) begin
        statQ     <= '0;
        standbyQ  <= 1'b0;
        sawStartQ <= 1'b0;
        waitHoldQ <= 1'b0;
      end
    end
  end

  assign statusOut = statQ;
  assign standby   = standbyQ;
  assign sclDrvLow = waitHoldQ;
  assign sdaDrvLow = setOk && statQ[S_TRC] && txBitLow;
endmodule

// File: rtl/i2c_ctl_seq.sv
module i2c_ctl_seq
  import i2c_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [CTRL_W-1:0] wrData,
  output logic [CTRL_W-1:0] rdData,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              filterOn,
  input  logic              evStart,
  input  logic              evStop,
  input  logic              evAddrMatch,
  input  logic              evExtCode,
  input  logic              evAckDet,
  input  logic              setMaster,
  input  logic              setTx,
  input  logic              ninthWait,
  input  logic              txBitLow,
  output logic [STAT_W-1:0] statusOut,
  output logic              sclDrvLow,
  output logic              sdaDrvLow,
  output logic              standby
);
  ctlStrobe_t strobe;

  i2c_ctl_regs u_regs (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .sclIn(sclIn), .sdaIn(sdaIn), .filterOn(filterOn),
    .rdData(rdData), .strobe(strobe)
  );

  i2c_ctl_flags u_flags (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .evStart(evStart), .evStop(evStop), .evAddrMatch(evAddrMatch),
    .evExtCode(evExtCode), .evAckDet(evAckDet), .setMaster(setMaster),
    .setTx(setTx), .ninthWait(ninthWait), .txBitLow(txBitLow),
    .statusOut(statusOut), .sclDrvLow(sclDrvLow), .sdaDrvLow(sdaDrvLow),
    .standby(standby)
  );
endmodule

// File: rtl/i2c_ctl_seq_chk.sv
module i2c_ctl_seq_chk
  import i2c_ctl_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              wrEn,
  input logic [CTRL_W-1:0] wrData,
  input logic [CTRL_W-1:0] rdData,
  input logic              evStop,
  input logic              ninthWait,
  input logic [STAT_W-1:0] statusOut,
  input logic              sclDrvLow,
  input logic              sdaDrvLow,
  input logic              standby
);
  p_disabled_quiet_r3: assert property (@(posedge clk) disable iff (!rstN)
    !rdData[B_EN] |-> statusOut == '0);

  p_disable_clears_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && rdData[B_EN] && !wrData[B_EN]) |=> (statusOut == '0 && !sclDrvLow && !standby));

  p_exit_clears_r5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && rdData[B_EN] && wrData[B_EN] && wrData[B_EXIT])
      |=> (standby && (statusOut & EXIT_CLR) == '0 && !rdData[B_STT] && !rdData[B_SPT]));

  p_lines_released_r5: assert property (@(posedge clk) disable iff (!rstN)
    standby |-> (!sclDrvLow && !sdaDrvLow));

  p_stop_ends_standby_r7: assert property (@(posedge clk) disable iff (!rstN)
    (standby && evStop && !wrEn) |=> !standby);

  p_scl_from_wait_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sclDrvLow) |-> $past(ninthWait));
endmodule

bind i2c_ctl_seq i2c_ctl_seq_chk u_chk (.*);

// File: tb/i2c_ctl_seq_bench.sv
`timescale 1ns/1ps
module i2c_ctl_seq_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic sclIn = 1'b1, sdaIn = 1'b1, filterOn = 1'b0;
  logic evStart = 0, evStop = 0, evAddrMatch = 0, evExtCode = 0, evAckDet = 0;
  logic setMaster = 0, setTx = 0, ninthWait = 0, txBitLow = 1'b1;
  logic [7:0] statusOut;
  logic sclDrvLow, sdaDrvLow, standby;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  i2c_ctl_seq u_i2c_ctl_seq (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdData(rdData),
    .sclIn(sclIn), .sdaIn(sdaIn), .filterOn(filterOn),
    .evStart(evStart), .evStop(evStop), .evAddrMatch(evAddrMatch),
    .evExtCode(evExtCode), .evAckDet(evAckDet), .setMaster(setMaster),
    .setTx(setTx), .ninthWait(ninthWait), .txBitLow(txBitLow),
    .statusOut(statusOut), .sclDrvLow(sclDrvLow), .sdaDrvLow(sdaDrvLow),
    .standby(standby)
  );

  // ev: [0]start [1]stop [2]addr [3]ext [4]ack [5]master [6]tx [7]ninthWait
  typedef struct packed {
    logic       wr;
    logic [7:0] data;
    logic [7:0] ev;
    logic [7:0] expRd;
    logic [7:0] expStat;
    logic       expScl;
    logic       expSda;
    logic       expSb;
    logic [7:0] req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VT [NV] = '{
    '{1'b1, 8'h1C, 8'h00, 8'h00, 8'h00, 0, 0, 0, 8'd3},  // R3 write ignored
    '{1'b0, 8'h00, 8'h01, 8'h00, 8'h00, 0, 0, 0, 8'd3},  // R3 start ignored
    '{1'b1, 8'h80, 8'h00, 8'h80, 8'h00, 0, 0, 0, 8'd2},
    '{1'b1, 8'h9D, 8'h00, 8'h9D, 8'h00, 0, 0, 0, 8'd2},  // R2 readback
    '{1'b0, 8'h00, 8'h01, 8'h9D, 8'h42, 0, 0, 0, 8'd5},
    '{1'b0, 8'h00, 8'h60, 8'h9D, 8'hCA, 0, 1, 0, 8'd5},
    '{1'b0, 8'h00, 8'h10, 8'h9D, 8'hCE, 0, 1, 0, 8'd5},
    '{1'b0, 8'h00, 8'h80, 8'h9D, 8'hCE, 1, 1, 0, 8'd9},  // R9 wait holds SCL
    '{1'b1, 8'hBD, 8'h00, 8'h9D, 8'hC6, 0, 0, 0, 8'd10}, // R10 release in tx
    '{1'b0, 8'h00, 8'h44, 8'h9D, 8'hDE, 0, 1, 0, 8'd5},
    '{1'b1, 8'hDD, 8'h00, 8'h9C, 8'h40, 0, 0, 1, 8'd5},  // R5 exit
    '{1'b0, 8'h00, 8'hF0, 8'h9C, 8'h40, 0, 0, 1, 8'd6},  // R6 ignored in standby
    '{1'b0, 8'h00, 8'h04, 8'h9C, 8'h40, 0, 0, 1, 8'd8},  // R8 no start yet
    '{1'b0, 8'h00, 8'h01, 8'h9C, 8'h42, 0, 0, 1, 8'd8},
    '{1'b0, 8'h00, 8'h04, 8'h9C, 8'h52, 0, 0, 0, 8'd8},  // R8 wake on match
    '{1'b1, 8'hDC, 8'h00, 8'h9C, 8'h40, 0, 0, 1, 8'd5},
    '{1'b0, 8'h00, 8'h02, 8'h9C, 8'h01, 0, 0, 0, 8'd7},  // R7 stop wakes
    '{1'b0, 8'h00, 8'h20, 8'h9C, 8'h81, 0, 0, 0, 8'd7},
    '{1'b1, 8'h1C, 8'h00, 8'h00, 8'h00, 0, 0, 0, 8'd4}   // R4 disable
  };

  task automatic check(input string req, input logic [7:0] rd, input logic [7:0] st,
                       input logic scl, input logic sda, input logic sb);
    checks++;
    if (rdData !== rd || statusOut !== st || sclDrvLow !== scl ||
        sdaDrvLow !== sda || standby !== sb) begin
      fails++;
      $display("FAIL %s: got rd=%h st=%h scl=%b sda=%b sb=%b, expected rd=%h st=%h scl=%b sda=%b sb=%b",
               req, rdData, statusOut, sclDrvLow, sdaDrvLow, standby, rd, st, scl, sda, sb);
    end
  endtask

  task automatic step(input logic wr, input logic [7:0] d, input logic [7:0] ev);
    wrEn = wr; wrData = d;
    {ninthWait, setTx, setMaster, evAckDet, evExtCode, evAddrMatch, evStop, evStart} = ev;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
    {ninthWait, setTx, setMaster, evAckDet, evExtCode, evAddrMatch, evStop, evStart} = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    check("R1", 8'h00, 8'h00, 0, 0, 0);

    for (int i = 0; i < NV; i++) begin
      step(VT[i].wr, VT[i].data, VT[i].ev);
      check($sformatf("R%0d", VT[i].req), VT[i].expRd, VT[i].expStat,
            VT[i].expScl, VT[i].expSda, VT[i].expSb);
    end

    // R9: wait release with no pending wait changes nothing
    step(1, 8'h80, 8'h00);
    step(0, 8'h00, 8'h40);
    check("R9", 8'h80, 8'h08, 0, 1, 0);
    step(1, 8'hA0, 8'h00);
    check("R9", 8'h80, 8'h08, 0, 1, 0);
    // R4: disable during a wait releases SCL
    step(0, 8'h00, 8'h80);
    check("R4", 8'h80, 8'h08, 1, 1, 0);
    step(1, 8'h00, 8'h00);
    check("R4", 8'h00, 8'h00, 0, 0, 0);

    // R11: enable with SCL high, SDA low, filter on
    sclIn = 1'b1; sdaIn = 1'b0; filterOn = 1'b1;
    step(1, 8'h80, 8'h00);
    check("R11", 8'h80, 8'h42, 0, 0, 0);
    step(1, 8'hC0, 8'h00);
    check("R11", 8'h80, 8'h40, 0, 0, 1);
    step(1, 8'h00, 8'h00);
    filterOn = 1'b0;
    step(1, 8'h80, 8'h00);
    check("R11", 8'h80, 8'h00, 0, 0, 0);
    sdaIn = 1'b1;

    // R12: exit wins over same-cycle sets
    step(1, 8'hC0, 8'h64);
    check("R12", 8'h80, 8'h00, 0, 0, 1);
    // R8: extension code after start wakes
    step(0, 8'h00, 8'h01);
    step(0, 8'h00, 8'h08);
    check("R8", 8'h80, 8'h62, 0, 0, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule